// File: doc/BRIEF.md
# Hessian Determinant Box-Filter Pipeline

This block turns one sliding-window position of an integral image into a blob-strength score for a single box-filter size. For each of the three second-order derivative estimates (horizontal, vertical and mixed), the caller presents four integral-image corner samples. The block forms each box sum, scales it by a weight tied to the filter side length, and combines the three into a determinant-of-Hessian value. The mixed term is damped by a fixed factor of 0.81. Beside the score it returns a one-bit sign of the trace, which later stages use to tell bright blobs from dark ones.

The datapath is a fixed-depth pipeline with no internal buffering. A single enable, driven by the downstream ready, either advances every stage at once or freezes every stage at once. The upstream ready is therefore the downstream ready passed through. One instance serves one filter size. A parameter picks that size from a table of eight side lengths, so a bank of instances covers all scales.

Top module: `hfp_hessian_pipe`

## Requirements
- R1: Each corner bundle packs four unsigned 32-bit integral samples: a in bits [31:0], b in [63:32], c in [95:64], d in [127:96]. The box sum is a − b − c + d, computed exactly as a signed value with no wrap.
- R2: Each box sum is normalized as floor(sum × W / 2^20). W = floor((2^20 + floor(s²/2)) / s²), where s is the filter side length.
- R3: Bits [31:0] of the output word are the low 32 bits of P − floor(X × K / 2^16). P is the normalized horizontal term times the normalized vertical term. X is the normalized mixed term squared. K = 53084, which is 0.81 in 16 fractional bits.
- R4: Output bit 32 is 1 when the horizontal box sum plus the vertical box sum is zero or positive, and 0 when that sum is negative.
- R5: When ready stays high, a result leaves 18 rising edges after its input. The accepting edge counts as the first of these, so out_valid is seen after 17 further edges.
- R6: While out_ready is low, every stage holds its contents. A pending out_valid and its out_data stay unchanged, and no item moves toward the output.
- R7: in_ready equals out_ready. An input presented while in_ready is low is ignored and produces no result.
- R8: Every accepted input produces exactly one result, in acceptance order, and no result appears without an input.
- R9: While reset is asserted, and on the first cycle after it is released, out_valid is low.
- R10: Parameter FILTER_IDX 0..7 selects side lengths 9, 15, 21, 27, 39, 51, 75 and 99 in that order. Instances with different sizes keep the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A window position is presented |
| in_ready | output | 1 | Block accepts the presented position |
| xx_corners | input | 128 | Four corners of the horizontal second-derivative box |
| yy_corners | input | 128 | Four corners of the vertical second-derivative box |
| xy_corners | input | 128 | Four corners of the mixed second-derivative box |
| out_ready | input | 1 | Destination can take a result; low freezes the pipeline |
| out_valid | output | 1 | A result is present |
| out_data | output | 33 | Bit 32 trace sign, bits [31:0] response |

## Verification
The bench drives corner bundles that give the largest positive box sum and the largest negative one. A design that sized its box sum too narrowly would wrap these and flip both the score and the sign bit. It also sets up traces that are exactly zero and exactly minus one. A sign test written as strictly greater than zero, or one that read the wrong bit, gets one of these cases wrong. An item is stalled mid-pipe for many cycles while fresh inputs are offered. A stage that ignored the freeze would release the item early, lose it, or admit the ignored inputs. A second instance at the largest side length runs in lockstep with the first. It exposes weight rounding and table-order errors, and shows whether the two sizes keep the same timing.

// File: rtl/hfp_pkg.sv
package hfp_pkg;

   localparam int NUM_FILTERS = 8;
   localparam int NUM_LANES   = 3;
   localparam int LANE_XX     = 0;
   localparam int LANE_YY     = 1;
   localparam int LANE_XY     = 2;

   // side length of the square box filter for a given scale index
   function automatic int side_of(input int idx);
      case (idx)
         0:       return 9;
         1:       return 15;
         2:       return 21;
         3:       return 27;
         4:       return 39;
         5:       return 51;
         6:       return 75;
         default: return 99;
      endcase
   endfunction

   // rounded fixed-point value of 1/side^2 with frac fractional bits
   function automatic longint weight_of(input int side, input int frac);
      longint sq;
      sq = longint'(side) * longint'(side);
      return ((longint'(1) << frac) + sq / 2) / sq;
   endfunction

   // 0.81 rounded to frac fractional bits
   function automatic longint cf_of(input int frac);
      return (longint'(81) * (longint'(1) << frac) + 50) / 100;
   endfunction

endpackage

// File: rtl/hfp_delay.sv
module hfp_delay #(
   parameter int WIDTH = 1,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("hfp_delay: WIDTH must be at least 1");
   end
   if (DEPTH < 0) begin : g_bad_depth
      $error("hfp_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, en};
      assign q = d;
   end else begin : g_regs
      logic [WIDTH-1:0] stage_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
         end else if (en) begin
            stage_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
         end
      end
      assign q = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/hfp_mul_pipe.sv
module hfp_mul_pipe #(
   parameter int A_W   = 34,
   parameter int B_W   = 22,
   parameter int DEPTH = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic signed [A_W-1:0]     a,
   input  logic signed [B_W-1:0]     b,
   output logic signed [A_W+B_W-1:0] p
);

   localparam int P_W = A_W + B_W;

   if (DEPTH < 1) begin : g_bad_depth
      $error("hfp_mul_pipe: DEPTH must be at least 1");
   end

   logic signed [A_W-1:0] a_q;
   logic signed [B_W-1:0] b_q;
   logic signed [P_W-1:0] prod;
   logic        [P_W-1:0] tail_q;

   // operand capture is the first of DEPTH registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (en) begin
         a_q <= a;
         b_q <= b;
      end
   end

   always_comb prod = P_W'(a_q) * P_W'(b_q);

   // remaining registers give the multiplier room to be retimed
   hfp_delay #(.WIDTH(P_W), .DEPTH(DEPTH - 1)) u_tail (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d    (prod),
      .q    (tail_q)
   );

   assign p = $signed(tail_q);

endmodule

// File: rtl/hfp_box_sum.sv
module hfp_box_sum #(
   parameter int PIX_W = 32,
   parameter int DEPTH = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [4*PIX_W-1:0]    corners,
   output logic signed [PIX_W+1:0] sum
);

   localparam int S_W = PIX_W + 2;

   if (DEPTH < 1) begin : g_bad_depth
      $error("hfp_box_sum: DEPTH must be at least 1");
   end

   logic signed [S_W-1:0] c_a, c_b, c_c, c_d, sum_d;
   logic        [S_W-1:0] sum_q;

   // zero-extend each unsigned corner; two guard bits keep the sum exact
   assign c_a   = S_W'(corners[0*PIX_W +: PIX_W]);
   assign c_b   = S_W'(corners[1*PIX_W +: PIX_W]);
   assign c_c   = S_W'(corners[2*PIX_W +: PIX_W]);
   assign c_d   = S_W'(corners[3*PIX_W +: PIX_W]);
   assign sum_d = c_a - c_b - c_c + c_d;

   hfp_delay #(.WIDTH(S_W), .DEPTH(DEPTH)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d    (sum_d),
      .q    (sum_q)
   );

   assign sum = $signed(sum_q);

endmodule

// File: rtl/hfp_hessian_pipe.sv
module hfp_hessian_pipe
   import hfp_pkg::*;
#(
   parameter int PIX_W      = 32,
   parameter int FILTER_IDX = 0,
   parameter int WFRAC      = 20,
   parameter int CF_FRAC    = 16,
   parameter int NORM_W     = 34,
   parameter int RESP_W     = 32,
   parameter int SUM_LAT    = 1,
   parameter int NORM_LAT   = 6,
   parameter int PROD_LAT   = 6,
   parameter int CF_LAT     = 4,
   parameter int SUB_LAT    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [4*PIX_W-1:0] xx_corners,
   input  logic [4*PIX_W-1:0] yy_corners,
   input  logic [4*PIX_W-1:0] xy_corners,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [RESP_W:0]   out_data
);

   localparam int SUM_W     = PIX_W + 2;
   localparam int SIDE      = side_of(FILTER_IDX);
   localparam int WT_W      = WFRAC + 2;
   localparam int NP_W      = SUM_W + WT_W;
   localparam int PR_W      = 2 * NORM_W;
   localparam int CFK_W     = CF_FRAC + 2;
   localparam int CP_W      = PR_W + CFK_W;
   localparam int TAIL_LAT  = NORM_LAT + PROD_LAT + CF_LAT + SUB_LAT;
   localparam int TOTAL_LAT = SUM_LAT + TAIL_LAT;
   localparam logic signed [WT_W-1:0]  WEIGHT = WT_W'(weight_of(SIDE, WFRAC));
   localparam logic signed [CFK_W-1:0] CF_K   = CFK_W'(cf_of(CF_FRAC));

   // elaboration-time parameter checks
   if (FILTER_IDX < 0 || FILTER_IDX >= NUM_FILTERS) begin : g_bad_idx
      $error("hfp_hessian_pipe: FILTER_IDX out of range");
   end
   if (WFRAC < 8 || WFRAC > 30) begin : g_bad_wfrac
      $error("hfp_hessian_pipe: WFRAC must lie in 8..30");
   end
   if (CF_FRAC < 8 || CF_FRAC > 30) begin : g_bad_cffrac
      $error("hfp_hessian_pipe: CF_FRAC must lie in 8..30");
   end
   if (NORM_W < SUM_W) begin : g_bad_norm
      $error("hfp_hessian_pipe: NORM_W narrower than the box sum");
   end
   if (RESP_W > PR_W) begin : g_bad_resp
      $error("hfp_hessian_pipe: RESP_W wider than the product");
   end
   if (SUM_LAT < 1 || NORM_LAT < 1 || PROD_LAT < 1 || CF_LAT < 1 || SUB_LAT < 1) begin : g_bad_lat
      $error("hfp_hessian_pipe: every stage needs at least one register");
   end

   // one enable freezes or advances the whole pipe
   logic en;
   assign en       = out_ready;
   assign in_ready = out_ready;

   // ---------------- box sums and normalization, one lane per term
   logic [4*PIX_W-1:0]      lane_corners [NUM_LANES];
   logic signed [SUM_W-1:0] box          [NUM_LANES];
   logic signed [NP_W-1:0]  nprod        [NUM_LANES];
   logic signed [NORM_W-1:0] norm        [NUM_LANES];

   assign lane_corners[LANE_XX] = xx_corners;
   assign lane_corners[LANE_YY] = yy_corners;
   assign lane_corners[LANE_XY] = xy_corners;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      hfp_box_sum #(.PIX_W(PIX_W), .DEPTH(SUM_LAT)) u_box (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (en),
         .corners(lane_corners[l]),
         .sum    (box[l])
      );

      hfp_mul_pipe #(.A_W(SUM_W), .B_W(WT_W), .DEPTH(NORM_LAT)) u_norm (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (en),
         .a    (box[l]),
         .b    (WEIGHT),
         .p    (nprod[l])
      );

      // drop the fraction bits: floor division by 2^WFRAC
      assign norm[l] = NORM_W'(nprod[l] >>> WFRAC);
   end

   // ---------------- trace sign taken from the exact box sums
   logic signed [SUM_W:0] trace_sum;
   logic                  lap_now;
   logic                  lap_q;

   assign trace_sum = (SUM_W+1)'(box[LANE_XX]) + (SUM_W+1)'(box[LANE_YY]);
   assign lap_now   = (trace_sum >= 0);

   hfp_delay #(.WIDTH(1), .DEPTH(TAIL_LAT)) u_lap (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d    (lap_now),
      .q    (lap_q)
   );

   // ---------------- products and square
   logic signed [PR_W-1:0] xxyy, xy2;

   hfp_mul_pipe #(.A_W(NORM_W), .B_W(NORM_W), .DEPTH(PROD_LAT)) u_xxyy (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .a    (norm[LANE_XX]),
      .b    (norm[LANE_YY]),
      .p    (xxyy)
   );

   hfp_mul_pipe #(.A_W(NORM_W), .B_W(NORM_W), .DEPTH(PROD_LAT)) u_xy2 (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .a    (norm[LANE_XY]),
      .b    (norm[LANE_XY]),
      .p    (xy2)
   );

   // ---------------- compensation multiply, direct product kept aligned
   logic signed [CP_W-1:0] cfp;
   logic        [PR_W-1:0] xxyy_al;
   logic signed [PR_W-1:0] cf_term, diff;

   hfp_mul_pipe #(.A_W(PR_W), .B_W(CFK_W), .DEPTH(CF_LAT)) u_cf (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .a    (xy2),
      .b    (CF_K),
      .p    (cfp)
   );

   hfp_delay #(.WIDTH(PR_W), .DEPTH(CF_LAT)) u_xxyy_al (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d    (xxyy),
      .q    (xxyy_al)
   );

   assign cf_term = PR_W'(cfp >>> CF_FRAC);
   assign diff    = $signed(xxyy_al) - cf_term;

   // ---------------- final subtract register
   logic [RESP_W-1:0] resp_d, resp_q;
   assign resp_d = RESP_W'(diff);

   hfp_delay #(.WIDTH(RESP_W), .DEPTH(SUB_LAT)) u_sub (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d    (resp_d),
      .q    (resp_q)
   );

   // ---------------- valid travels beside the data
   hfp_delay #(.WIDTH(1), .DEPTH(TOTAL_LAT)) u_vld (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d    (in_valid),
      .q    (out_valid)
   );

   assign out_data = {lap_q, resp_q};

endmodule

// File: rtl/hfp_hessian_chk.sv
module hfp_hessian_chk #(
   parameter int TOTAL_LAT = 18,
   parameter int RESP_W    = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            out_ready,
   input logic            out_valid,
   input logic [RESP_W:0] out_data
);

   // items accepted but not yet delivered
   logic [15:0] inflight;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else inflight <= inflight + 16'(in_valid && in_ready) - 16'(out_valid && out_ready);
   end

   // R9: quiet on the first cycle out of reset
   p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !out_valid);

   // R6: a held result keeps its value
   p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R6: nothing reaches the output during a stall
   p_freeze_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !out_ready) |=> !out_valid);

   // R8: every result has an accepted input behind it
   p_no_phantom_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (inflight != 16'd0));

   // R5: occupancy cannot exceed the number of stages
   p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= 16'(TOTAL_LAT));

endmodule

bind hfp_hessian_pipe hfp_hessian_chk #(
   .TOTAL_LAT(SUM_LAT + NORM_LAT + PROD_LAT + CF_LAT + SUB_LAT),
   .RESP_W   (RESP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_ready(out_ready),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/tb_hfp_hessian_pipe.sv
module tb_hfp_hessian_pipe;

   localparam int LAT = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         out_ready = 1'b0;
   logic [127:0] xx = '0, yy = '0, xy = '0;
   logic         in_ready, in_ready99, out_valid, out_valid99;
   logic [32:0]  out_data, out_data99;

   always #5 clk = ~clk;

   hfp_hessian_pipe #(.FILTER_IDX(0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .xx_corners(xx), .yy_corners(yy), .xy_corners(xy),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data));

   hfp_hessian_pipe #(.FILTER_IDX(7)) dut99 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready99),
      .xx_corners(xx), .yy_corners(yy), .xy_corners(xy),
      .out_ready(out_ready), .out_valid(out_valid99), .out_data(out_data99));

   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;
   logic [65:0] exp_q [$];
   logic        prev_valid = 1'b0;
   logic        prev_ready = 1'b1;
   logic [32:0] prev_data = '0;

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // R1: exact signed box sum of four unsigned corners
   function automatic logic signed [127:0] bsum(input logic [127:0] c);
      return $signed({96'd0, c[31:0]}) - $signed({96'd0, c[63:32]})
           - $signed({96'd0, c[95:64]}) + $signed({96'd0, c[127:96]});
   endfunction

   // R2, R3, R4: expected output word
   function automatic logic [32:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] c, input int side);
      logic signed [127:0] bx, by, bq, w, nx, ny, nq, k, p, q, r;
      bx = bsum(a);
      by = bsum(b);
      bq = bsum(c);
      w  = ((128'sd1 <<< 20) + 128'(side * side / 2)) / 128'(side * side);
      nx = (bx * w) >>> 20;
      ny = (by * w) >>> 20;
      nq = (bq * w) >>> 20;
      k  = (128'sd81 * (128'sd1 <<< 16) + 128'sd50) / 128'sd100;
      p  = nx * ny;
      q  = (nq * nq * k) >>> 16;
      r  = p - q;
      return {((bx + by) >= 0), r[31:0]};
   endfunction

   function automatic logic [127:0] pack(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d);
      return {d, c, b, a};
   endfunction

   function automatic logic [127:0] rnd_corners();
      logic [127:0] r;
      logic [31:0]  m;
      case ($urandom % 3)
         0:       m = 32'hFFFF_FFFF;
         1:       m = 32'h000F_FFFF;
         default: m = 32'h0000_0FFF;
      endcase
      for (int i = 0; i < 4; i++) r[i*32 +: 32] = $urandom & m;
      return r;
   endfunction

   // one clock: drive at the falling edge, inspect, then wait one period
   task automatic cycle(input bit v, input bit rdy, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] c);
      logic [65:0] e;
      in_valid = v; out_ready = rdy; xx = a; yy = b; xy = c;
      #1;
      check(in_ready == rdy && in_ready99 == rdy, "R7 in_ready follows out_ready",
            {in_ready99, in_ready}, {rdy, rdy});
      check(out_valid99 == out_valid, "R10 sizes share timing", out_valid99, out_valid);
      if (prev_valid && !prev_ready)
         check(out_valid && out_data == prev_data, "R6 held result",
               {out_valid, out_data}, {1'b1, prev_data});
      if (out_valid && rdy) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 result without input", out_data, 0);
         end else begin
            e = exp_q.pop_front();
            // R1 R2 R3 R4 for side 9
            check(out_data == e[32:0], "R3 R4 side 9 result", out_data, e[32:0]);
            check(out_data99 == e[65:33], "R10 R2 side 99 result", out_data99, e[65:33]);
         end
      end
      if (v && rdy) exp_q.push_back({model(a, b, c, 99), model(a, b, c, 9)});
      prev_valid = out_valid;
      prev_ready = rdy;
      prev_data  = out_data;
      @(negedge clk);
   endtask

   task automatic wait_latency(input string req);
      int lat = 0;
      while (!out_valid && lat < 40) begin
         cycle(1'b0, 1'b1, '0, '0, '0);
         lat++;
      end
      check(lat == LAT - 1, req, lat, LAT - 1);
   endtask

   initial begin
      void'($urandom(32'd7031));
      repeat (3) @(negedge clk);
      check(!out_valid && !out_valid99, "R9 valid low in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !out_valid99, "R9 valid low after reset", out_valid, 0);

      // R5: latency through an empty pipe
      cycle(1'b1, 1'b1, pack(100, 3, 7, 900), pack(50, 1, 2, 400), pack(30, 1, 1, 90));
      wait_latency("R5 latency");
      repeat (5) cycle(1'b0, 1'b1, '0, '0, '0);

      // directed corners: R1 extremes, R4 sign boundary
      cycle(1'b1, 1'b1, '0, '0, '0);
      cycle(1'b1, 1'b1, pack('1, 0, 0, '1), pack('1, 0, 0, '1), pack('1, 0, 0, '1));
      cycle(1'b1, 1'b1, pack(0, '1, '1, 0), pack(0, '1, '1, 0), pack(0, '1, '1, 0));
      cycle(1'b1, 1'b1, pack('1, 0, 0, '1), pack(0, '1, '1, 0), pack(0, '1, 0, 0));
      cycle(1'b1, 1'b1, pack(5, 0, 0, 0), pack(0, 5, 0, 0), pack(9, 0, 0, 0));
      cycle(1'b1, 1'b1, pack(4, 0, 0, 0), pack(0, 5, 0, 0), pack(0, 9, 0, 0));
      cycle(1'b1, 1'b1, pack(40000, 0, 0, 0), pack(90000, 0, 0, 0), pack(0, 0, 70000, 0));
      repeat (25) cycle(1'b0, 1'b1, '0, '0, '0);

      // R6 and R7: stall with an item deep inside, offered inputs ignored
      cycle(1'b1, 1'b1, pack(800, 0, 0, 0), pack(900, 0, 0, 0), pack(0, 300, 0, 0));
      repeat (6) cycle(1'b0, 1'b1, '0, '0, '0);
      for (int i = 0; i < 25; i++) begin
         cycle(1'b1, 1'b0, rnd_corners(), rnd_corners(), rnd_corners());
         check(!out_valid, "R6 frozen pipe releases nothing", out_valid, 0);
      end
      begin
         int lat = 0;
         while (!out_valid && lat < 40) begin
            cycle(1'b0, 1'b1, '0, '0, '0);
            lat++;
         end
         check(lat == LAT - 7, "R6 remaining stages after stall", lat, LAT - 7);
      end
      repeat (25) cycle(1'b0, 1'b1, '0, '0, '0);
      check(exp_q.size() == 0, "R7 ignored inputs gave no result", exp_q.size(), 0);

      // random traffic with random backpressure
      for (int i = 0; i < 4000; i++)
         cycle(($urandom % 4) != 0, ($urandom % 4) != 0, rnd_corners(), rnd_corners(), rnd_corners());

      repeat (40) cycle(1'b0, 1'b1, '0, '0, '0);
      check(exp_q.size() == 0, "R8 every accepted input delivered", exp_q.size(), 0);
      check(!out_valid, "R8 pipe empty after drain", out_valid, 0);

      finished = 1'b1;
      report();
   end

   initial begin
      #(64'd200000 * 10);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R8 watchdog actual=hung expected=done");
         report();
      end
   end

endmodule